// File: doc/BRIEF.md
# Two-to-Four-Phase Handshake Converter

This block joins a transition-signalling handshake to a return-to-zero handshake. On the upstream side, any change of the request level (rising or falling) asks for one transfer, and the block answers by flipping its acknowledge level once the work is done. On the downstream side, the block raises a request, waits for the acknowledge to change, lowers the request, and waits for the acknowledge to change back. The upstream acknowledge flips only after that whole downstream cycle has finished.

The block is a clocked emulation of this behaviour. At each rising clock edge, the block compares each input with the level it last accepted, and a difference counts as an event. Each output reacts at the same edge that samples its enabling event. A sticky error flag catches two kinds of protocol violation: an upstream request that changes again before it has been acknowledged, and a downstream acknowledge that changes while no downstream cycle is open.

Top module: `hs2to4_conv`

## Requirements
- R1: While reset is held, and right after it is released, `up_ack`, `dn_req` and `proto_err` are low, and the block waits for an upstream event.
- R2: When the block is idle and `up_req` differs from its last accepted level, `dn_req` is high after that same rising edge.
- R3: While `dn_req` is high, the first change of `dn_ack` drives `dn_req` low at the edge that samples it. `dn_req` never falls without such a change.
- R4: After `dn_req` has fallen, the next change of `dn_ack` flips `up_ack` at the edge that samples it. This is the only way `up_ack` changes, so once a cycle ends, `up_ack` equals `up_req`.
- R5: `up_ack` and `dn_req` never change on the same edge, and both hold their levels while no enabling event arrives.
- R6: A change of `up_req` while a cycle is open (`dn_req` high, or `up_ack` not yet equal to the accepted request) sets `proto_err`.
- R7: A change of `dn_ack` while the block is idle sets `proto_err`.
- R8: Once `proto_err` is set, it stays high until reset.
- R9: Rising and falling changes of `up_req` each start a cycle, so the block runs any number of cycles back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_req | input | 1 | Upstream transition-signalled request |
| up_ack | output | 1 | Upstream transition-signalled acknowledge |
| dn_req | output | 1 | Downstream return-to-zero request |
| dn_ack | input | 1 | Downstream return-to-zero acknowledge |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
On every cycle, the assertions check the causal links: each rise and fall of `dn_req` and each flip of `up_ack` must follow its own input event, the two outputs must never move together, and both error conditions must set a flag that then stays set. Only the bench scenarios can show the full ordering over long runs with random gaps. They also show that `up_ack` returns to parity with `up_req` after every cycle, in both polarities, that outputs hold steady through idle gaps, and that reset clears a raised flag.

// File: rtl/hs2to4_conv.sv
module hs2to4_conv (
  input  logic clk,
  input  logic rst_n,
  input  logic up_req,
  output logic up_ack,
  output logic dn_req,
  input  logic dn_ack,
  output logic proto_err
);

  typedef enum logic [1:0] {ST_IDLE, ST_RAISED, ST_LOWERED} phase_t;

  phase_t phase;
  logic   a_seen;
  logic   d_seen;
  logic   a_evt;
  logic   d_evt;

  assign a_evt = up_req != a_seen;
  assign d_evt = dn_ack != d_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= ST_IDLE;
      a_seen    <= 1'b0;
      d_seen    <= 1'b0;
      up_ack    <= 1'b0;
      dn_req    <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      d_seen <= dn_ack;
      unique case (phase)
        ST_IDLE: begin
          if (d_evt) proto_err <= 1'b1;
          if (a_evt) begin
            a_seen <= up_req;
            dn_req <= 1'b1;
            phase  <= ST_RAISED;
          end
        end
        ST_RAISED: begin
          if (a_evt) proto_err <= 1'b1;
          if (d_evt) begin
            dn_req <= 1'b0;
            phase  <= ST_LOWERED;
          end
        end
        ST_LOWERED: begin
          if (a_evt) proto_err <= 1'b1;
          if (d_evt) begin
            up_ack <= ~up_ack;
            phase  <= ST_IDLE;
          end
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hs2to4_conv_checker.sv
module hs2to4_conv_checker (
  input logic clk,
  input logic rst_n,
  input logic up_req,
  input logic up_ack,
  input logic dn_req,
  input logic dn_ack,
  input logic proto_err,
  input logic a_seen,
  input logic d_seen
);

  logic busy;
  assign busy = dn_req || (up_ack != a_seen);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!up_ack && !dn_req && !proto_err));

  a_r2_raise_needs_a: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_req) |-> $past(up_req != a_seen));

  a_r3_fall_needs_d: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dn_req) |-> $past(dn_ack != d_seen));

  a_r4_ack_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(up_ack) |-> (!dn_req && $past(!dn_req) && $past(dn_ack != d_seen)));

  a_r5_never_together: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(up_ack) |-> $stable(dn_req));

  a_r6_early_req: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && up_req != a_seen) |=> proto_err);

  a_r7_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && dn_ack != d_seen) |=> proto_err);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

endmodule

bind hs2to4_conv hs2to4_conv_checker u_chk (
  .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_ack(up_ack),
  .dn_req(dn_req), .dn_ack(dn_ack), .proto_err(proto_err),
  .a_seen(a_seen), .d_seen(d_seen)
);

// File: tb/hs2to4_conv_bench.sv
module hs2to4_conv_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_req = 1'b0;
  logic dn_ack = 1'b0;
  logic up_ack, dn_req, proto_err;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  hs2to4_conv u_hs2to4_conv (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_ack(up_ack),
    .dn_req(dn_req), .dn_ack(dn_ack), .proto_err(proto_err)
  );

  function automatic logic ack_after_cycle(logic req_level);
    return req_level;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    up_req = 1'b0;
    dn_ack = 1'b0;
    @(negedge clk);
    check("R1 ack in reset", up_ack, 1'b0);
    check("R1 req in reset", dn_req, 1'b0);
    check("R1 err in reset", proto_err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req after release", dn_req, 1'b0);
  endtask

  task automatic idle_gap(int n, logic exp_ack, logic exp_req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R5 ack holds", up_ack, exp_ack);
      check("R5 req holds", dn_req, exp_req);
    end
  endtask

  task automatic full_cycle(int g1, int g2, int g3);
    logic ack0;
    ack0 = up_ack;
    up_req = ~up_req;
    @(negedge clk);
    check("R2 req raised", dn_req, 1'b1);
    check("R5 ack steady on raise", up_ack, ack0);
    idle_gap(g1, ack0, 1'b1);
    dn_ack = ~dn_ack;
    @(negedge clk);
    check("R3 req lowered", dn_req, 1'b0);
    check("R5 ack steady on lower", up_ack, ack0);
    idle_gap(g2, ack0, 1'b0);
    dn_ack = ~dn_ack;
    @(negedge clk);
    check("R4 ack matches req", up_ack, ack_after_cycle(up_req));
    check("R4 req stays low", dn_req, 1'b0);
    idle_gap(g3, up_ack, 1'b0);
    check("R9 no error in clean cycle", proto_err, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();

    full_cycle(0, 0, 0);
    full_cycle(0, 0, 0);
    for (int k = 0; k < 60; k++)
      full_cycle($urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 5));

    // R6: early change while raised
    do_reset();
    up_req = 1'b1;
    @(negedge clk);
    check("R2 raised before early", dn_req, 1'b1);
    up_req = 1'b0;
    @(negedge clk);
    check("R6 early req while raised", proto_err, 1'b1);
    idle_gap(3, 1'b0, 1'b1);
    check("R8 err held", proto_err, 1'b1);

    // R6: early change while lowered
    do_reset();
    up_req = 1'b1;
    @(negedge clk);
    dn_ack = 1'b1;
    @(negedge clk);
    check("R3 lowered before early", dn_req, 1'b0);
    up_req = 1'b0;
    @(negedge clk);
    check("R6 early req while lowered", proto_err, 1'b1);
    check("R4 ack not flipped by early req", up_ack, 1'b0);

    // R7: stray ack while idle
    do_reset();
    dn_ack = 1'b1;
    @(negedge clk);
    check("R7 stray ack", proto_err, 1'b1);
    check("R7 no req from stray ack", dn_req, 1'b0);
    check("R7 no ack from stray ack", up_ack, 1'b0);
    repeat ($urandom_range(2, 6)) @(negedge clk);
    check("R8 err still held", proto_err, 1'b1);
    do_reset();
    check("R8 reset clears err", proto_err, 1'b0);

    full_cycle(1, 2, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule